// File: doc/BRIEF.md
# Battery Monitor Sleep and Protection Control

This unit decides whether a battery monitor is awake or asleep and owns the byte that holds its protection flags and FET enables. It watches the level of the host bus line. When that line stays low for longer than a programmable number of timebase ticks, the unit releases the general-purpose pin. If sleep is permitted, it also drops into sleep, where both FET control outputs go to their off (high) level. The unit wakes when the bus line returns high, provided sleep is permitted. It also wakes when the power-switch input is pulled low. Every wake re-arms both enables.

Protection events from the analog side arrive as one-cycle pulses. Each one sets a sticky flag. A set flag holds its FET off until the host clears the flag by writing a 0 to it. The host writes a shared data byte with one of two strobes: one for the protection byte and one for the pin-control byte. Both bytes can be read back at any time.

Top module: `batt_pwr_ctrl`

## Requirements
- R1: After reset the unit is awake, all four fault flags are 0, both enables are 1, both FET outputs are on (0), the general-purpose pin is released, and the protection byte reads 8'h03.
- R2: With sleep permitted, the unit enters sleep on the tick that completes TIMEOUT_TICKS consecutive ticks with the bus line low. One tick fewer does not put it to sleep.
- R3: With sleep not permitted, a bus-low timeout never moves the unit into sleep.
- R4: A bus-low timeout releases the general-purpose pin (drive-low output 0, pin bit set to 1), whether or not sleep is permitted.
- R5: Writing 0 to pin-control bit 0 turns the pull-low driver on, and writing 1 turns it off. Reading the pin-control byte returns the sensed pin level in bit 0 and the power-switch level in bit 1; the other bits read 0.
- R6: While asleep, both FET outputs are off (1). With sleep permitted, the bus line going high wakes the unit on the next clock.
- R7: A low power-switch level wakes the unit from sleep. While awake, the power-switch level changes only pin-control bit 1 and never the mode.
- R8: Every wake sets both enables (protection bits 1 and 0) to 1, even if they were cleared while asleep.
- R9: Fault flags sit in protection bits 7 (overvoltage), 6 (undervoltage), 5 (charge overcurrent) and 4 (discharge overcurrent). An event sets its flag. The flag stays set through writes of 1 and is cleared only by a write of 0 to its bit.
- R10: A fault event in the same cycle as a clearing write leaves the flag set.
- R11: Writing 0 to the charge enable (bit 1) or the discharge enable (bit 0) forces that FET output off. Protection bits 3 and 2 read back the charge and discharge output levels.
- R12: A set overvoltage or charge-overcurrent flag forces the charge output off. A set undervoltage or discharge-overcurrent flag forces the discharge output off.
- R13: A bus-line high before the timeout completes restarts the low-time count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase tick for the bus-low timeout |
| bus_lvl_i | input | 1 | Synchronized host bus line level |
| sw_lvl_i | input | 1 | Synchronized power-switch pin level, low = pressed |
| gp_pin_i | input | 1 | Sensed level of the general-purpose pin |
| sleep_allow_i | input | 1 | Sleep permitted (from the status configuration) |
| ov_evt_i | input | 1 | Overvoltage event pulse |
| uv_evt_i | input | 1 | Undervoltage event pulse |
| coc_evt_i | input | 1 | Charge overcurrent event pulse |
| doc_evt_i | input | 1 | Discharge overcurrent event pulse |
| prot_wr_i | input | 1 | Write strobe for the protection byte |
| feat_wr_i | input | 1 | Write strobe for the pin-control byte |
| wdata_i | input | 8 | Host write data |
| chg_off_o | output | 1 | Charge FET control, 1 = off |
| dis_off_o | output | 1 | Discharge FET control, 1 = off |
| gp_drv_low_o | output | 1 | General-purpose pin pull-low driver enable |
| sleep_o | output | 1 | 1 while in sleep |
| prot_rdata_o | output | 8 | Protection byte read value |
| feat_rdata_o | output | 8 | Pin-control byte read value |

## Verification
The bus-low timeout is tried three ways. First, the line is held one tick short of the limit, which separates an off-by-one from the correct count. Next, the line bounces high just before the limit, which shows whether the count restarts. Last, the full timeout runs with sleep forbidden, which keeps the pin release apart from the sleep entry. Wake-up is driven once by the bus line and once by the power switch, with the enables cleared while asleep, so the re-arm is seen on both paths. The fault flags are exercised with writes of 1, with writes of 0, and with an event that coincides with a clearing write, which sorts out the priority between set and clear.

// File: rtl/pwr_prot_pkg.sv
// Package: shared bit positions and types for the sleep/protection unit.
// Assumes: the protection byte layout is fixed because the host decodes it.
package pwr_prot_pkg;
    // Protection byte bit positions
    localparam int PB_OV  = 7;
    localparam int PB_UV  = 6;
    localparam int PB_COC = 5;
    localparam int PB_DOC = 4;
    localparam int PB_CCM = 3;
    localparam int PB_DCM = 2;
    localparam int PB_CE  = 1;
    localparam int PB_DE  = 0;
    localparam int NUM_FAULTS = 4;

    // Pin-control byte bit positions
    localparam int FB_GP = 0;
    localparam int FB_SW = 1;

    typedef enum logic {
        MODE_ACTIVE = 1'b0,
        MODE_SLEEP  = 1'b1
    } pmode_t;
endpackage

// File: rtl/lowbus_timer.sv
// Module: lowbus_timer
// Counts timebase ticks while the bus line is low and flags the tick that
// completes TIMEOUT_TICKS of them. The count saturates, so the timeout
// pulse fires once per low period. A high bus level clears the count.
// Assumes: bus_lvl_i is already synchronized; TIMEOUT_TICKS >= 1.
module lowbus_timer #(
    parameter int TIMEOUT_TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic bus_lvl_i,
    output logic timeout_o
);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] low_cnt_q;

    // Purpose: count low ticks, restart on high, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt_q <= '0;
        else if (bus_lvl_i)
            low_cnt_q <= '0;
        else if (tick_i && (low_cnt_q != LIMIT))
            low_cnt_q <= low_cnt_q + CNT_W'(1);
    end

    // Purpose: mark the tick that completes the low period.
    always_comb begin
        timeout_o = !bus_lvl_i && tick_i && (low_cnt_q == LAST);
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_q <= LIMIT);

    // R2
    timeout_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (low_cnt_q == LIMIT));

    // R13
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lvl_i |=> (low_cnt_q == '0));
endmodule

// File: rtl/mode_fsm.sv
// Module: mode_fsm
// Two-state power mode machine. Sleep is entered on a bus-low timeout
// when sleep is permitted. Sleep is left when the bus goes high (if
// permitted) or when the power switch is pulled low.
// Assumes: inputs are synchronous to clk.
module mode_fsm
    import pwr_prot_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   timeout_i,
    input  logic   sleep_allow_i,
    input  logic   bus_lvl_i,
    input  logic   sw_lvl_i,
    output pmode_t mode_o,
    output logic   wake_o
);
    pmode_t mode_q;
    logic   enter_sleep;

    // Purpose: decode the entry and wake conditions from the current mode.
    always_comb begin
        enter_sleep = (mode_q == MODE_ACTIVE) && timeout_i && sleep_allow_i;
        wake_o      = (mode_q == MODE_SLEEP) &&
                      ((sleep_allow_i && bus_lvl_i) || !sw_lvl_i);
    end

    // Purpose: hold the power mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_ACTIVE;
        else if (enter_sleep)
            mode_q <= MODE_SLEEP;
        else if (wake_o)
            mode_q <= MODE_ACTIVE;
    end

    assign mode_o = mode_q;

    // R3
    no_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_allow_i && mode_q == MODE_ACTIVE) |=> (mode_q == MODE_ACTIVE));

    // R2
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ACTIVE && !timeout_i) |=> (mode_q == MODE_ACTIVE));

    // R7
    sw_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SLEEP && !sw_lvl_i) |=> (mode_q == MODE_ACTIVE));
endmodule

// File: rtl/prot_reg.sv
// Module: prot_reg
// Protection byte: four sticky fault flags, two enables, and the FET
// control outputs derived from them. A flag is cleared only by writing 0
// to it, and a same-cycle event wins over the clear. A wake re-arms both
// enables and wins over a same-cycle write.
// Assumes: fault events are single-cycle pulses, ordered {ov, uv, coc, doc}.
module prot_reg
    import pwr_prot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wake_i,
    input  logic                  sleeping_i,
    input  logic [NUM_FAULTS-1:0] fault_evt_i,
    input  logic                  wr_i,
    input  logic [NUM_FAULTS-1:0] flag_wbits_i,
    input  logic [1:0]            en_wbits_i,
    output logic                  chg_off_o,
    output logic                  dis_off_o,
    output logic [7:0]            rdata_o
);
    logic [NUM_FAULTS-1:0] flag_q;
    logic                  ce_q;
    logic                  de_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FAULTS; gi++) begin : g_flag
            // Purpose: one sticky fault flag, event beats clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q[gi] <= 1'b0;
                else if (fault_evt_i[gi])
                    flag_q[gi] <= 1'b1;
                else if (wr_i && !flag_wbits_i[gi])
                    flag_q[gi] <= 1'b0;
            end

            // R10
            flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fault_evt_i[gi] |=> flag_q[gi]);

            // R9
            flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[gi] && !(wr_i && !flag_wbits_i[gi])) |=> flag_q[gi]);
        end
    endgenerate

    // Purpose: charge and discharge enables, re-armed on every wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q <= 1'b1;
            de_q <= 1'b1;
        end else if (wake_i) begin
            ce_q <= 1'b1;
            de_q <= 1'b1;
        end else if (wr_i) begin
            ce_q <= en_wbits_i[1];
            de_q <= en_wbits_i[0];
        end
    end

    // Purpose: FET levels from mode, enables and the relevant flags.
    always_comb begin
        chg_off_o = sleeping_i || !ce_q || flag_q[3] || flag_q[1];
        dis_off_o = sleeping_i || !de_q || flag_q[2] || flag_q[0];
    end

    // Purpose: assemble the readable protection byte.
    always_comb begin
        rdata_o         = '0;
        rdata_o[PB_OV]  = flag_q[3];
        rdata_o[PB_UV]  = flag_q[2];
        rdata_o[PB_COC] = flag_q[1];
        rdata_o[PB_DOC] = flag_q[0];
        rdata_o[PB_CCM] = chg_off_o;
        rdata_o[PB_DCM] = dis_off_o;
        rdata_o[PB_CE]  = ce_q;
        rdata_o[PB_DE]  = de_q;
    end

    // R8
    wake_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> (ce_q && de_q));
endmodule

// File: rtl/gpio_ctl.sv
// Module: gpio_ctl
// General-purpose pin control bit and the pin-control read byte. The bit
// drives the pull-low driver when 0. A bus-low timeout forces it to 1,
// which wins over a same-cycle host write.
// Assumes: pin and switch levels are synchronized by the caller.
module gpio_ctl
    import pwr_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timeout_i,
    input  logic       wr_i,
    input  logic       wr_bit_i,
    input  logic       pin_lvl_i,
    input  logic       sw_lvl_i,
    output logic       drv_low_o,
    output logic [7:0] rdata_o
);
    logic gp_bit_q;

    // Purpose: hold the pin control bit, forced released on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gp_bit_q <= 1'b1;
        else if (timeout_i)
            gp_bit_q <= 1'b1;
        else if (wr_i)
            gp_bit_q <= wr_bit_i;
    end

    // Purpose: drive the pin and assemble the read byte from sensed levels.
    always_comb begin
        drv_low_o      = !gp_bit_q;
        rdata_o        = '0;
        rdata_o[FB_GP] = pin_lvl_i;
        rdata_o[FB_SW] = sw_lvl_i;
    end

    // R4
    gp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_i |=> !drv_low_o);
endmodule

// File: rtl/batt_pwr_ctrl.sv
// Module: batt_pwr_ctrl (top)
// Sleep/active mode control and protection byte for a battery monitor.
// Wires the bus-low timer, mode machine, protection byte and pin control.
// Assumes: all level inputs are synchronized to clk, events are pulses,
// and the bus protocol engine produces the write strobes and data.
module batt_pwr_ctrl
    import pwr_prot_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       bus_lvl_i,
    input  logic       sw_lvl_i,
    input  logic       gp_pin_i,
    input  logic       sleep_allow_i,
    input  logic       ov_evt_i,
    input  logic       uv_evt_i,
    input  logic       coc_evt_i,
    input  logic       doc_evt_i,
    input  logic       prot_wr_i,
    input  logic       feat_wr_i,
    input  logic [7:0] wdata_i,
    output logic       chg_off_o,
    output logic       dis_off_o,
    output logic       gp_drv_low_o,
    output logic       sleep_o,
    output logic [7:0] prot_rdata_o,
    output logic [7:0] feat_rdata_o
);
    logic   timeout;
    logic   wake;
    pmode_t mode;

    lowbus_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .bus_lvl_i (bus_lvl_i),
        .timeout_o (timeout)
    );

    mode_fsm u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .timeout_i     (timeout),
        .sleep_allow_i (sleep_allow_i),
        .bus_lvl_i     (bus_lvl_i),
        .sw_lvl_i      (sw_lvl_i),
        .mode_o        (mode),
        .wake_o        (wake)
    );

    assign sleep_o = (mode == MODE_SLEEP);

    prot_reg u_prot (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_i       (wake),
        .sleeping_i   (sleep_o),
        .fault_evt_i  ({ov_evt_i, uv_evt_i, coc_evt_i, doc_evt_i}),
        .wr_i         (prot_wr_i),
        .flag_wbits_i (wdata_i[PB_OV:PB_DOC]),
        .en_wbits_i   (wdata_i[PB_CE:PB_DE]),
        .chg_off_o    (chg_off_o),
        .dis_off_o    (dis_off_o),
        .rdata_o      (prot_rdata_o)
    );

    gpio_ctl u_gpio (
        .clk       (clk),
        .rst_n     (rst_n),
        .timeout_i (timeout),
        .wr_i      (feat_wr_i),
        .wr_bit_i  (wdata_i[FB_GP]),
        .pin_lvl_i (gp_pin_i),
        .sw_lvl_i  (sw_lvl_i),
        .drv_low_o (gp_drv_low_o),
        .rdata_o   (feat_rdata_o)
    );

    // R6
    sleep_fet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> (chg_off_o && dis_off_o && !gp_drv_low_o));
endmodule

// File: tb/test_batt_pwr_ctrl.sv
// Scoreboard bench: the driver pushes expected output vectors into a queue
// and blocks until the monitor has popped and compared each one.
module test_batt_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 6;

    typedef struct {
        string       req;
        logic [19:0] exp;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic bus = 1'b1;
    logic sw = 1'b1;
    logic gp_pin = 1'b1;
    logic allow = 1'b1;
    logic ov = 0, uv = 0, coc = 0, doc = 0;
    logic prot_wr = 0, feat_wr = 0;
    logic [7:0] wdata = '0;
    logic chg_off, dis_off, drv_low, sleeping;
    logic [7:0] prot_rd, feat_rd;

    sb_item_t sb_q[$];
    int pending = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    batt_pwr_ctrl #(.TIMEOUT_TICKS(TO)) i_batt_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_lvl_i(bus),
        .sw_lvl_i(sw), .gp_pin_i(gp_pin), .sleep_allow_i(allow),
        .ov_evt_i(ov), .uv_evt_i(uv), .coc_evt_i(coc), .doc_evt_i(doc),
        .prot_wr_i(prot_wr), .feat_wr_i(feat_wr), .wdata_i(wdata),
        .chg_off_o(chg_off), .dis_off_o(dis_off), .gp_drv_low_o(drv_low),
        .sleep_o(sleeping), .prot_rdata_o(prot_rd), .feat_rdata_o(feat_rd)
    );

    // Monitor: pop each expected vector and compare with the live outputs.
    initial begin
        forever begin
            sb_item_t it;
            logic [19:0] got;
            wait (pending > 0);
            it = sb_q.pop_front();
            got = {sleeping, chg_off, dis_off, drv_low, prot_rd, feat_rd};
            n_vec++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %05h expected %05h (sleep,chg,dis,drv,prot,feat)",
                         it.req, got, it.exp);
            end
            pending--;
        end
    end

    // Driver side: queue one expected vector and wait for it to be compared.
    task automatic expect_out(input string req, input logic sl, input logic co,
                              input logic dof, input logic drv, input logic [7:0] pr);
        sb_item_t it;
        it.req = req;
        it.exp = {sl, co, dof, drv, pr, 6'b0, sw, gp_pin};
        sb_q.push_back(it);
        pending++;
        wait (pending == 0);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_prot(input logic [7:0] d);
        prot_wr = 1; wdata = d; step(1); prot_wr = 0;
    endtask

    task automatic wr_feat(input logic [7:0] d);
        feat_wr = 1; wdata = d; step(1); feat_wr = 0;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        expect_out("R1 reset state", 0, 0, 0, 0, 8'h03);

        // R5: driver on, off, and sensed levels
        wr_feat(8'h00);
        expect_out("R5 write 0 drives low", 0, 0, 0, 1, 8'h03);
        gp_pin = 0; step(1);
        expect_out("R5 sensed pin level", 0, 0, 0, 1, 8'h03);
        wr_feat(8'h01);
        expect_out("R5 write 1 releases", 0, 0, 0, 0, 8'h03);
        wr_feat(8'h00);
        gp_pin = 1;

        // R13 / R2: one tick short, restart, then full timeout
        bus = 0; step(TO-1);
        expect_out("R2 one tick short", 0, 0, 0, 1, 8'h03);
        bus = 1; step(1);
        bus = 0; step(TO-1);
        expect_out("R13 count restarted", 0, 0, 0, 1, 8'h03);
        step(1);
        expect_out("R2 R4 R6 enter sleep", 1, 1, 1, 0, 8'h0F);

        // R8 / R6: clear enables while asleep, wake on bus high
        wr_prot(8'h00);
        expect_out("R8 enables cleared asleep", 1, 1, 1, 0, 8'h0C);
        bus = 1; step(1);
        expect_out("R6 R8 bus wake re-arms", 0, 0, 0, 0, 8'h03);

        // R7: power switch wake, then switch only mirrors
        bus = 0; step(TO);
        expect_out("R2 sleep again", 1, 1, 1, 0, 8'h0F);
        sw = 0; step(1);
        expect_out("R7 switch wake", 0, 0, 0, 0, 8'h03);
        step(2);
        expect_out("R7 switch low while awake", 0, 0, 0, 0, 8'h03);
        sw = 1; step(1);
        expect_out("R7 switch mirror", 0, 0, 0, 0, 8'h03);

        // R3 / R4: timeout with sleep forbidden
        bus = 1; step(1);
        allow = 0;
        wr_feat(8'h00);
        bus = 0; step(TO+2);
        expect_out("R3 R4 no sleep, pin released", 0, 0, 0, 0, 8'h03);
        bus = 1; allow = 1; step(1);

        // R11: enable writes
        wr_prot(8'h02);
        expect_out("R11 discharge disabled", 0, 0, 1, 0, 8'h06);
        wr_prot(8'h01);
        expect_out("R11 charge disabled", 0, 1, 0, 0, 8'h09);
        wr_prot(8'h03);

        // R9 / R12: flag set, write 1 keeps, write 0 clears
        ov = 1; step(1); ov = 0;
        expect_out("R9 R12 overvoltage", 0, 1, 0, 0, 8'h8B);
        wr_prot(8'hFF);
        expect_out("R9 write 1 keeps flag", 0, 1, 0, 0, 8'h8B);
        wr_prot(8'h7F);
        expect_out("R9 write 0 clears", 0, 0, 0, 0, 8'h03);
        uv = 1; step(1); uv = 0;
        doc = 1; step(1); doc = 0;
        expect_out("R12 undervoltage and discharge oc", 0, 0, 1, 0, 8'h57);
        wr_prot(8'h03);
        coc = 1; step(1); coc = 0;
        expect_out("R12 charge oc", 0, 1, 0, 0, 8'h2B);
        wr_prot(8'h03);
        expect_out("R9 all cleared", 0, 0, 0, 0, 8'h03);

        // R10: event beats a same-cycle clear
        doc = 1; prot_wr = 1; wdata = 8'h03; step(1);
        doc = 0; prot_wr = 0;
        expect_out("R10 event wins over clear", 0, 0, 1, 0, 8'h17);
        wr_prot(8'h03);
        expect_out("R10 later clear", 0, 0, 0, 0, 8'h03);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule